// File: doc/BRIEF.md
# Bit-Serial 8-Point Inverse DCT

This block computes a one-dimensional 8-point inverse discrete cosine transform. Spectral coefficients arrive one bit per clock on two serial lines. One line carries the even-indexed coefficients and the other carries the odd-indexed ones. The transform is split into an even half-matrix and an odd half-matrix. Four multiply-accumulate lanes compute the even partial sums and four compute the odd partial sums, all running in parallel. Each lane forms a coefficient product one input bit at a time: it adds a selected constant to a running partial sum that is halved on every step.

A shared output stage adds each even/odd pair to produce the first four spatial samples. It subtracts each pair to produce the last four, rounds all eight to 16 bits, and presents them together with a one-cycle valid pulse. A caller that builds a two-dimensional transform feeds rows through this block. It waits for each valid pulse before starting the next row.

Top module: `idct8_serial_da`

## Requirements
- R1: While reset is held and in the first cycle after release, `valid_o` is 0 and `y_o` is all zeros.
- R2: Each input coefficient is a 12-bit two's complement word sent least significant bit first. The cycle in which `start_i` is accepted is cycle 0. Bit k of even word u is sampled from `bit_even_i` in cycle 12u+k, and the same holds for odd word u on `bit_odd_i`. The even words are X0, X2, X4, X6 in that order and the odd words are X1, X3, X5, X7 in that order.
- R3: The constants are held as signed integers scaled by 2^13: a=5793, b=7568, c=3135, d=8035, e=6811, f=4551, g=1598. The even rows are (a,b,a,c), (a,c,-a,-b), (a,-c,-a,b), (a,-b,a,-c). The odd rows are (d,e,f,g), (e,-g,-d,-f), (f,-d,g,e), (g,-f,e,-d).
- R4: For i in 0..3, let W_i be even row i dotted with (X0,X2,X4,X6) and M_i be odd row i dotted with (X1,X3,X5,X7). Output x_i is then round((W_i+M_i)/2^14).
- R5: For i in 0..3, output x_(7-i) is round((W_i−M_i)/2^14).
- R6: Rounding adds 2^13 and then takes the floor of the division by 2^14, so halves go toward positive infinity.
- R7: `valid_o` is high for exactly one cycle, in cycle 52. `y_o` changes only in a cycle where `valid_o` is high and otherwise holds its last value.
- R8: A `start_i` pulse in cycles 1 to 51 of a running block is ignored. A `start_i` in cycle 52 (the valid cycle) starts a new block.
- R9: `y_o[16k+15:16k]` carries x_k for k = 0..7.
- R10: Every 12-bit input value is transformed exactly, including −2048 and +2047. The sign bit carries weight −2^11.

Ports in order of the port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Block start strobe, sampled together with the first input bits |
| bit_even_i | input | 1 | Serial bit of the even-indexed coefficients |
| bit_odd_i | input | 1 | Serial bit of the odd-indexed coefficients |
| y_o | output | 128 | Eight 16-bit spatial samples, x_k in bits 16k+15:16k |
| valid_o | output | 1 | One-cycle pulse marking a fresh result on y_o |

## Verification
The assertions take for granted that `start_i` and both serial inputs carry defined levels every cycle after reset, and that the serial bits are meaningful only in the 48 cycles after an accepted start. The checker follows accepted starts with its own counter, so it tolerates strobes raised mid-block. The stimulus changes inputs only on the falling edge and keeps every coefficient inside −2048..2047. It sweeps each input position with both extreme values, the all-maximum and all-minimum vectors, and random blocks. It also covers back-to-back starts on the valid cycle and a stray start in the middle of a block.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int COEF_W = 14;
    localparam int FRAC   = 13;
    localparam int HALF   = 4;
    localparam int NPT    = 2 * HALF;

    localparam int K_A = 5793;
    localparam int K_B = 7568;
    localparam int K_C = 3135;
    localparam int K_D = 8035;
    localparam int K_E = 6811;
    localparam int K_F = 4551;
    localparam int K_G = 1598;

    // Even (odd_sel=0) or odd (odd_sel=1) half-matrix entry, row r, column k.
    function automatic logic signed [COEF_W-1:0] coef(input logic odd_sel, input int r, input int k);
        int v;
        v = 0;
        if (!odd_sel) begin
            case (r * 4 + k)
                0:  v =  K_A;  1:  v =  K_B;  2:  v =  K_A;  3:  v =  K_C;
                4:  v =  K_A;  5:  v =  K_C;  6:  v = -K_A;  7:  v = -K_B;
                8:  v =  K_A;  9:  v = -K_C;  10: v = -K_A;  11: v =  K_B;
                12: v =  K_A;  13: v = -K_B;  14: v =  K_A;  15: v = -K_C;
                default: v = 0;
            endcase
        end else begin
            case (r * 4 + k)
                0:  v =  K_D;  1:  v =  K_E;  2:  v =  K_F;  3:  v =  K_G;
                4:  v =  K_E;  5:  v = -K_G;  6:  v = -K_D;  7:  v = -K_F;
                8:  v =  K_F;  9:  v = -K_D;  10: v =  K_G;  11: v =  K_E;
                12: v =  K_G;  13: v = -K_F;  14: v =  K_E;  15: v = -K_D;
                default: v = 0;
            endcase
        end
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/idct8_ctrl.sv
module idct8_ctrl #(
    parameter int IN_W   = 12,
    parameter int HALF   = 4,
    parameter int DRAIN  = 4,
    parameter int BIT_W  = $clog2(IN_W),
    parameter int WORD_W = $clog2(HALF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              feed_o,
    output logic              clr_o,
    output logic              load_o,
    output logic [BIT_W-1:0]  bidx_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int FEED  = IN_W * HALF;
    localparam int LAT   = FEED + DRAIN;
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_FEED = CNT_W'(FEED);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(IN_W - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bidx;
        logic [WORD_W-1:0] word;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;
    logic  feed;
    logic  load;
    logic [BIT_W-1:0]  cur_b;
    logic [WORD_W-1:0] cur_w;

    always_comb begin
        accept = start_i && !st_q.busy;
        cur_b  = accept ? '0 : st_q.bidx;
        cur_w  = accept ? '0 : st_q.word;
        feed   = accept || (st_q.busy && (st_q.cnt < CNT_FEED));
        load   = st_q.busy && (st_q.cnt == CNT_LAST);

        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(1);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (load) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end
        end
        if (feed) begin
            if (cur_b == BIT_LAST) begin
                st_d.bidx = '0;
                st_d.word = cur_w + WORD_W'(1);
            end else begin
                st_d.bidx = cur_b + BIT_W'(1);
                st_d.word = cur_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign feed_o = feed;
    assign clr_o  = accept;
    assign load_o = load;
    assign bidx_o = cur_b;
    assign word_o = cur_w;

endmodule

// File: rtl/idct8_mac.sv
module idct8_mac #(
    parameter int IN_W   = 12,
    parameter int ODD    = 0,
    parameter int ROW    = 0,
    parameter int BIT_W  = $clog2(IN_W),
    parameter int WORD_W = 2,
    parameter int ACC_W  = idct8_pkg::COEF_W + IN_W + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    en_i,
    input  logic                    bit_i,
    input  logic [BIT_W-1:0]        bidx_i,
    input  logic [WORD_W-1:0]       word_i,
    output logic signed [ACC_W-1:0] sum_o
);
    localparam int PART_W = idct8_pkg::COEF_W + IN_W + 2;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(IN_W - 1);

    typedef struct packed {
        logic signed [PART_W-1:0] part;
        logic signed [ACC_W-1:0]  sum;
    } mac_t;

    mac_t st_d, st_q;
    logic signed [idct8_pkg::COEF_W-1:0] kval;
    logic signed [PART_W-1:0] term;
    logic signed [PART_W-1:0] base;
    logic signed [PART_W-1:0] nxt;

    always_comb begin
        kval = idct8_pkg::coef(ODD != 0, ROW, int'(word_i));
        // bit weight 2^IN_W before the halvings that follow
        term = bit_i ? (PART_W'(kval) <<< IN_W) : '0;
        if (bidx_i == BIT_LAST) term = -term;
        base = (bidx_i == '0) ? '0 : st_q.part;
        nxt  = (base + term) >>> 1;

        st_d = st_q;
        if (clr_i) st_d.sum = '0;
        if (en_i) begin
            st_d.part = nxt;
            if (bidx_i == BIT_LAST) st_d.sum = st_d.sum + ACC_W'(nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;

endmodule

// File: rtl/idct8_bfly.sv
module idct8_bfly #(
    parameter int HALF  = 4,
    parameter int ACC_W = 30,
    parameter int OUT_W = 16,
    parameter int FRAC  = 13
) (
    input  logic [HALF*ACC_W-1:0]    w_i,
    input  logic [HALF*ACC_W-1:0]    m_i,
    output logic [2*HALF*OUT_W-1:0]  y_o
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [SUM_W-1:0] RND = SUM_W'(1) <<< FRAC;

    for (genvar g = 0; g < HALF; g++) begin : g_pair
        logic signed [SUM_W-1:0] wv;
        logic signed [SUM_W-1:0] mv;
        assign wv = SUM_W'($signed(w_i[g*ACC_W +: ACC_W]));
        assign mv = SUM_W'($signed(m_i[g*ACC_W +: ACC_W]));
        assign y_o[g*OUT_W +: OUT_W] = OUT_W'((wv + mv + RND) >>> (FRAC + 1));
        assign y_o[(2*HALF-1-g)*OUT_W +: OUT_W] = OUT_W'((wv - mv + RND) >>> (FRAC + 1));
    end

endmodule

// File: rtl/idct8_serial_da.sv
module idct8_serial_da #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 16,
    parameter int DRAIN = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic                                 bit_even_i,
    input  logic                                 bit_odd_i,
    output logic [idct8_pkg::NPT*OUT_W-1:0]      y_o,
    output logic                                 valid_o
);
    localparam int HALF   = idct8_pkg::HALF;
    localparam int NPT    = idct8_pkg::NPT;
    localparam int BIT_W  = $clog2(IN_W);
    localparam int WORD_W = $clog2(HALF);
    localparam int ACC_W  = idct8_pkg::COEF_W + IN_W + 4;

    typedef struct packed {
        logic [NPT*OUT_W-1:0] y;
        logic                 valid;
    } out_t;

    logic              feed;
    logic              clr;
    logic              load;
    logic [BIT_W-1:0]  bidx;
    logic [WORD_W-1:0] word;
    logic [HALF*ACC_W-1:0] w_bus;
    logic [HALF*ACC_W-1:0] m_bus;
    logic [NPT*OUT_W-1:0]  y_comb;
    out_t st_d, st_q;

    idct8_ctrl #(
        .IN_W(IN_W), .HALF(HALF), .DRAIN(DRAIN), .BIT_W(BIT_W), .WORD_W(WORD_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .feed_o(feed), .clr_o(clr), .load_o(load),
        .bidx_o(bidx), .word_o(word)
    );

    for (genvar g = 0; g < HALF; g++) begin : g_lane
        logic signed [ACC_W-1:0] w_sum;
        logic signed [ACC_W-1:0] m_sum;

        idct8_mac #(
            .IN_W(IN_W), .ODD(0), .ROW(g), .BIT_W(BIT_W), .WORD_W(WORD_W), .ACC_W(ACC_W)
        ) u_even (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(feed), .bit_i(bit_even_i),
            .bidx_i(bidx), .word_i(word), .sum_o(w_sum)
        );

        idct8_mac #(
            .IN_W(IN_W), .ODD(1), .ROW(g), .BIT_W(BIT_W), .WORD_W(WORD_W), .ACC_W(ACC_W)
        ) u_odd (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(feed), .bit_i(bit_odd_i),
            .bidx_i(bidx), .word_i(word), .sum_o(m_sum)
        );

        assign w_bus[g*ACC_W +: ACC_W] = w_sum;
        assign m_bus[g*ACC_W +: ACC_W] = m_sum;
    end

    idct8_bfly #(
        .HALF(HALF), .ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC(idct8_pkg::FRAC)
    ) u_bfly (
        .w_i(w_bus), .m_i(m_bus), .y_o(y_comb)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = load;
        if (load) st_d.y = y_comb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o     = st_q.y;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/idct8_serial_da_chk.sv
module idct8_serial_da_chk #(
    parameter int LAT = 52,
    parameter int Y_W = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           valid_o,
    input logic [Y_W-1:0] y_o
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(LAT);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             take;

    assign hit  = run_q && (cnt_q == CNT_HIT);
    assign take = start_i && (!run_q || hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (take) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(1);
        end else if (hit) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_VALID_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o);        // R7
    AST_VALID_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> hit);             // R7
    AST_LATENCY_REACHED:  assert property (@(posedge clk) disable iff (!rst_n) hit |-> valid_o);             // R8
    AST_OUT_HOLD:         assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> $stable(y_o));   // R7

endmodule

bind idct8_serial_da idct8_serial_da_chk #(
    .LAT(IN_W * idct8_pkg::HALF + DRAIN),
    .Y_W(idct8_pkg::NPT * OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_o(valid_o), .y_o(y_o)
);

// File: tb/idct8_serial_da_bench.sv
`timescale 1ns/1ps
module idct8_serial_da_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic         bit_even_i;
    logic         bit_odd_i;
    logic [127:0] y_o;
    logic         valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int kp[16];
    int kq[16];

    always #4 clk = ~clk;

    idct8_serial_da u_idct8_serial_da (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bit_even_i(bit_even_i), .bit_odd_i(bit_odd_i),
        .y_o(y_o), .valid_o(valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 R4 R5 R6 R7 R8 R9 R10: one block, optional stray start in cycle 20
    task automatic run_block(input int xv[8], input bit poke);
        int ex[8];
        for (int c = 0; c < 52; c++) begin
            int u = c / 12;
            int k = c % 12;
            if (c < 48) begin
                bit_even_i = xv[2*u][k];
                bit_odd_i  = xv[2*u+1][k];
            end else begin
                bit_even_i = 1'b0;
                bit_odd_i  = 1'b0;
            end
            start_i = (c == 0) || (poke && c == 20);
            @(negedge clk);
            check((c == 51) ? "R7 valid in cycle 52" : (poke ? "R8 no early valid" : "R7 no early valid"),
                  int'(valid_o), (c == 51) ? 1 : 0);
        end
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            int sw = 0;
            int sm = 0;
            for (int u = 0; u < 4; u++) begin
                sw += kp[i*4+u] * xv[2*u];
                sm += kq[i*4+u] * xv[2*u+1];
            end
            ex[i]     = (sw + sm + 8192) >>> 14;
            ex[7 - i] = (sw - sm + 8192) >>> 14;
        end
        for (int j = 0; j < 8; j++) begin
            check((j < 4) ? "R4 R6 R9 sum output" : "R5 R6 R9 difference output",
                  int'($signed(y_o[16*j +: 16])), int'($signed(16'(ex[j]))));
        end
    endtask

    task automatic idle(input int n);
        start_i = 1'b0;
        bit_even_i = 1'b0;
        bit_odd_i = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int xv[8];
        int A = 5793, B = 7568, C = 3135, D = 8035, E = 6811, F = 4551, G = 1598;
        kp = '{A, B, A, C,  A, C, -A, -B,  A, -C, -A, B,  A, -B, A, -C};   // R3
        kq = '{D, E, F, G,  E, -G, -D, -F,  F, -D, G, E,  G, -F, E, -D};
        rst_n = 1'b0;
        start_i = 1'b0;
        bit_even_i = 1'b0;
        bit_odd_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(valid_o), 0);
        check("R1 y after reset", int'(y_o != '0), 0);

        // zeros
        xv = '{0, 0, 0, 0, 0, 0, 0, 0};
        run_block(xv, 0);
        // R3 R10: impulses with both extremes on every position
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int q = 0; q < 8; q++) xv[q] = 0;
                xv[p] = s ? -2048 : 2047;
                run_block(xv, 0);
                idle(p % 3);
            end
        end
        // R10 all-max and all-min, back to back on the valid cycle (R8)
        for (int q = 0; q < 8; q++) xv[q] = 2047;
        run_block(xv, 0);
        for (int q = 0; q < 8; q++) xv[q] = -2048;
        run_block(xv, 0);
        for (int q = 0; q < 8; q++) xv[q] = (q % 2) ? -2048 : 2047;
        run_block(xv, 0);
        // R8 stray start mid-block
        for (int q = 0; q < 8; q++) xv[q] = 100 * q - 350;
        run_block(xv, 1);
        // R6 small values exercise rounding
        for (int q = 0; q < 8; q++) xv[q] = q - 4;
        run_block(xv, 0);
        for (int q = 0; q < 8; q++) xv[q] = (q == 3) ? -1 : 1;
        run_block(xv, 0);
        // random blocks
        for (int b = 0; b < 40; b++) begin
            for (int q = 0; q < 8; q++) xv[q] = int'($urandom_range(0, 4095)) - 2048;
            run_block(xv, (b % 7) == 3);
            idle(b % 2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule